// File: doc/BRIEF.md
# Standby and Power-Up Sequencer

This controller sits beside a stereo oversampling audio converter and decides, from a single active-low standby request, which parts of the converter are alive. It drives five control levels: a gate enable for the internal logic clock, an enable for the analog section, an output enable for the serial port pins, a force-low for the overload flag, and a hold-low for the serial data line. The standby request is asynchronous, so it first passes through a flop synchroniser. The controller then walks a fixed chain: running, a timed shutdown, standby, a timed wake-up, a wait for valid filtered data, and running again.

The shutdown and the wake-up take different times. The shutdown is short and counted in system clocks. The wake-up has two parts. A clock-counted settling phase comes first. It is followed by a wait counted in sample periods, where one sample period is a fixed number of system clocks (256 by default). The length of that wait depends on the high-pass filter enable, because the filter needs far longer to settle. A standby request that arrives part-way through a wake-up sends the controller straight back into shutdown. A request released during a shutdown does not stop the shutdown. It only leads to a full wake-up afterwards, so even a very short pulse always ends in correct operation.

Top module: `stby_seq`

## Requirements
- R1: While reset is asserted, the outputs show the standby state: core_clk_en=0, ana_en=0, port_oe=0, ovl_force_lo=1, sd_hold_lo=1. The synchroniser resets to "standby requested", so a high stby_n_in at reset release starts a normal wake-up.
- R2: stby_n_in passes through SYNC_STAGES flops before the sequencer reacts. With the default of two stages, a change on stby_n_in made between two clock edges shows on the outputs after the third rising edge that follows it.
- R3: On entering shutdown, port_oe falls, ovl_force_lo and sd_hold_lo rise, and core_clk_en and ana_en stay high. After exactly DOWN_CYCLES clocks in shutdown, core_clk_en and ana_en both fall.
- R4: In standby, core_clk_en=0, ana_en=0, port_oe=0, ovl_force_lo=1 and sd_hold_lo=1.
- R5: Leaving standby turns on ana_en and core_clk_en while port_oe stays low for exactly UP_CYCLES clocks. After that, port_oe rises, ovl_force_lo falls, and sd_hold_lo stays high.
- R6: After port_oe rises, sd_hold_lo stays high for SAMPLE_DIV × WAIT_HPF_OFF clocks when hpf_on is 0, or for SAMPLE_DIV × WAIT_HPF_ON clocks when hpf_on is 1. It then falls, and all enables stay high while it is low.
- R7: The wait length uses hpf_on as sampled at the clock edge that ends the settling phase. Changes of hpf_on during the wait have no effect on when sd_hold_lo falls.
- R8: A standby request that arrives during the settling phase or the data wait starts the shutdown at once. port_oe does not rise, or sd_hold_lo does not fall, in that wake-up.
- R9: Once a shutdown has begun, releasing the request does not shorten it. The controller always passes through standby and then runs a full wake-up, so a standby pulse of any length ends with sd_hold_lo low again.
- R10: If the standby request and the end of the data wait occur on the same clock edge, the shutdown wins. sd_hold_lo never falls, and port_oe falls at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, free-running at SAMPLE_DIV times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_n_in | input | 1 | Asynchronous standby request, low requests standby |
| hpf_on | input | 1 | High-pass filter enable, selects the data-wait length |
| core_clk_en | output | 1 | Enable for the gated internal logic clock |
| ana_en | output | 1 | Enable for the analog section |
| port_oe | output | 1 | Output enable for the serial port pins (low means high impedance) |
| ovl_force_lo | output | 1 | Forces the overload flag low |
| sd_hold_lo | output | 1 | Holds serial data low until filtered data is valid |

## Verification
Two things can happen on the same clock edge: the end of the sample-period wait and a new standby request reaching the end of the synchroniser. The bench provokes this collision by dropping the request exactly three clocks before the edge on which the data would become valid. It then judges the result at the ports. sd_hold_lo must never go low, port_oe must fall on that very edge, and the clock and analog enables must drop a full shutdown period later.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [2:0] {
    ST_STANDBY = 3'd0,
    ST_DOWN    = 3'd1,
    ST_UP      = 3'd2,
    ST_WAIT    = 3'd3,
    ST_RUN     = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic clk_en;
    logic ana_en;
    logic oe;
    logic ovl_lo;
    logic hold_lo;
  } seq_out_t;

  // Number of sample periods to wait for settled filter output.
  function automatic int unsigned wait_samples(input logic hpf,
                                               input int unsigned off_n,
                                               input int unsigned on_n);
    return hpf ? on_n : off_n;
  endfunction

  // Larger of two counts, used to size counters.
  function automatic int unsigned max_u(input int unsigned a,
                                        input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Control levels for each sequencer state.
  function automatic seq_out_t decode_state(input seq_state_t st);
    seq_out_t o;
    case (st)
      ST_DOWN: o = '{clk_en: 1'b1, ana_en: 1'b1, oe: 1'b0, ovl_lo: 1'b1, hold_lo: 1'b1};
      ST_UP:   o = '{clk_en: 1'b1, ana_en: 1'b1, oe: 1'b0, ovl_lo: 1'b1, hold_lo: 1'b1};
      ST_WAIT: o = '{clk_en: 1'b1, ana_en: 1'b1, oe: 1'b1, ovl_lo: 1'b0, hold_lo: 1'b1};
      ST_RUN:  o = '{clk_en: 1'b1, ana_en: 1'b1, oe: 1'b1, ovl_lo: 1'b0, hold_lo: 1'b0};
      default: o = '{clk_en: 1'b0, ana_en: 1'b0, oe: 1'b0, ovl_lo: 1'b1, hold_lo: 1'b1};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RESET_VAL;
    else        chain[0] <= d_async;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= RESET_VAL;
      else        chain[g] <= chain[g-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/stby_prescale.sv
module stby_prescale #(
  parameter int unsigned DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;

  assign tick = active && (pcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (!active) pcnt <= '0;
    else if (tick)    pcnt <= '0;
    else              pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/stby_sample_cnt.sv
module stby_sample_cnt
  import stby_pkg::*;
#(
  parameter int unsigned WAIT_OFF = 1024,
  parameter int unsigned WAIT_ON  = 12288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic hpf_on,
  output logic expire
);
  localparam int unsigned MAXW = max_u(WAIT_OFF, WAIT_ON);
  localparam int CW = $clog2(MAXW + 1);

  logic [CW-1:0] scnt;
  logic          hpf_lat;
  logic [CW-1:0] last_cnt;

  assign last_cnt = CW'(wait_samples(hpf_lat, WAIT_OFF, WAIT_ON) - 1);
  assign expire   = active && tick && (scnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt    <= '0;
      hpf_lat <= 1'b0;
    end else if (!active) begin
      scnt    <= '0;
      hpf_lat <= hpf_on;
    end else if (tick) begin
      scnt    <= scnt + 1'b1;
    end
  end
endmodule

// File: rtl/stby_seq.sv
module stby_seq
  import stby_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned DOWN_CYCLES  = 32,
  parameter int unsigned UP_CYCLES    = 256,
  parameter int unsigned SAMPLE_DIV   = 256,
  parameter int unsigned WAIT_HPF_OFF = 1024,
  parameter int unsigned WAIT_HPF_ON  = 12288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_n_in,
  input  logic hpf_on,
  output logic core_clk_en,
  output logic ana_en,
  output logic port_oe,
  output logic ovl_force_lo,
  output logic sd_hold_lo
);
  localparam int unsigned CYC_MAX = max_u(DOWN_CYCLES, UP_CYCLES);
  localparam int CCW = (CYC_MAX > 1) ? $clog2(CYC_MAX) : 1;
  localparam logic [CCW-1:0] DOWN_LAST = CCW'(DOWN_CYCLES - 1);
  localparam logic [CCW-1:0] UP_LAST   = CCW'(UP_CYCLES - 1);

  seq_state_t     state, state_nxt;
  logic [CCW-1:0] cyc, cyc_nxt;
  seq_out_t       outs;

  // Named internal events
  logic awake_lvl;   // synchronised level, 1 = normal operation requested
  logic sb_req;      // standby requested
  logic down_done;   // shutdown period complete
  logic up_done;     // settling period complete
  logic in_wait;     // sample-period wait in progress
  logic smp_tick;    // one sample period elapsed
  logic data_ready;  // wait finished this cycle

  stby_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (stby_n_in),
    .q_sync  (awake_lvl)
  );

  assign sb_req    = !awake_lvl;
  assign in_wait   = (state == ST_WAIT);
  assign down_done = (state == ST_DOWN) && (cyc == DOWN_LAST);
  assign up_done   = (state == ST_UP) && (cyc == UP_LAST);

  stby_prescale #(.DIV(SAMPLE_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (in_wait),
    .tick   (smp_tick)
  );

  stby_sample_cnt #(.WAIT_OFF(WAIT_HPF_OFF), .WAIT_ON(WAIT_HPF_ON)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (in_wait),
    .tick   (smp_tick),
    .hpf_on (hpf_on),
    .expire (data_ready)
  );

  always_comb begin
    state_nxt = state;
    case (state)
      ST_STANDBY: if (!sb_req) state_nxt = ST_UP;
      ST_DOWN:    if (down_done) state_nxt = ST_STANDBY;
      ST_UP: begin
        if (sb_req)       state_nxt = ST_DOWN;
        else if (up_done) state_nxt = ST_WAIT;
      end
      ST_WAIT: begin
        if (sb_req)          state_nxt = ST_DOWN;
        else if (data_ready) state_nxt = ST_RUN;
      end
      ST_RUN:     if (sb_req) state_nxt = ST_DOWN;
      default:    state_nxt = ST_DOWN;
    endcase
  end

  always_comb begin
    if (state_nxt != state)                        cyc_nxt = '0;
    else if (state == ST_DOWN || state == ST_UP)   cyc_nxt = cyc + 1'b1;
    else                                           cyc_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_STANDBY;
      cyc   <= '0;
    end else begin
      state <= state_nxt;
      cyc   <= cyc_nxt;
    end
  end

  assign outs         = decode_state(state);
  assign core_clk_en  = outs.clk_en;
  assign ana_en       = outs.ana_en;
  assign port_oe      = outs.oe;
  assign ovl_force_lo = outs.ovl_lo;
  assign sd_hold_lo   = outs.hold_lo;
endmodule

// File: rtl/stby_seq_chk.sv
module stby_seq_chk #(
  parameter int unsigned DOWN_CYCLES  = 32,
  parameter int unsigned UP_CYCLES    = 256,
  parameter int unsigned SAMPLE_DIV   = 256,
  parameter int unsigned WAIT_HPF_OFF = 1024,
  parameter int unsigned WAIT_HPF_ON  = 12288
) (
  input logic clk,
  input logic rst_n,
  input logic hpf_on,
  input logic core_clk_en,
  input logic ana_en,
  input logic port_oe,
  input logic ovl_force_lo,
  input logic sd_hold_lo
);
  int unsigned up_cnt;
  int unsigned wait_cnt;
  logic        oe_q, hpf_q, hpf_lat;
  int unsigned exp_wait;

  assign exp_wait = SAMPLE_DIV * (hpf_lat ? WAIT_HPF_ON : WAIT_HPF_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt   <= 0;
      wait_cnt <= 0;
      oe_q     <= 1'b0;
      hpf_q    <= 1'b0;
      hpf_lat  <= 1'b0;
    end else begin
      oe_q  <= port_oe;
      hpf_q <= hpf_on;
      if (port_oe && !oe_q) hpf_lat <= hpf_q;
      if (!ana_en)       up_cnt <= 0;
      else if (!port_oe) up_cnt <= up_cnt + 1;
      if (!port_oe)        wait_cnt <= 0;
      else if (sd_hold_lo) wait_cnt <= wait_cnt + 1;
    end
  end

  assert_standby_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en |-> (!ana_en && !port_oe && ovl_force_lo && sd_hold_lo));

  assert_down_keeps_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_oe) |=> core_clk_en);

  assert_hold_with_port_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_hold_lo) |-> !port_oe);

  assert_settle_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_oe) |-> (up_cnt == UP_CYCLES));

  assert_wait_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_hold_lo) |-> (wait_cnt == exp_wait));

  assert_running_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_hold_lo |-> (port_oe && core_clk_en && ana_en && !ovl_force_lo));
endmodule

bind stby_seq stby_seq_chk #(
  .DOWN_CYCLES  (DOWN_CYCLES),
  .UP_CYCLES    (UP_CYCLES),
  .SAMPLE_DIV   (SAMPLE_DIV),
  .WAIT_HPF_OFF (WAIT_HPF_OFF),
  .WAIT_HPF_ON  (WAIT_HPF_ON)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hpf_on       (hpf_on),
  .core_clk_en  (core_clk_en),
  .ana_en       (ana_en),
  .port_oe      (port_oe),
  .ovl_force_lo (ovl_force_lo),
  .sd_hold_lo   (sd_hold_lo)
);

// File: tb/tb_stby_seq.sv
module tb_stby_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int DOWN = 8;
  localparam int UP   = 16;
  localparam int DIV  = 4;
  localparam int WOFF = 8;
  localparam int WON  = 24;
  localparam int LAT  = 3;  // two sync flops plus the state register
  localparam int EXP_OE = LAT + UP;
  localparam int EXP_RUN_OFF = EXP_OE + DIV * WOFF;
  localparam int EXP_RUN_ON  = EXP_OE + DIV * WON;

  // Wake-up vectors: hpf level at release, toggle hpf mid-wait, expected release cycle
  localparam logic VEC_HPF  [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic VEC_FLIP [4] = '{1'b0, 1'b0, 1'b1, 1'b1};
  localparam int   VEC_RUN  [4] = '{EXP_RUN_OFF, EXP_RUN_ON, EXP_RUN_OFF, EXP_RUN_ON};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby_n = 1'b1;
  logic hpf_in = 1'b0;
  logic core_clk_en, ana_en, port_oe, ovl_force_lo, sd_hold_lo;

  int n_checks = 0;
  int n_fail = 0;
  int r_ana_on, r_ana_off, r_oe_on, r_oe_off, r_clk_off, r_run;

  always #(CLK_PERIOD/2) clk = ~clk;

  stby_seq #(
    .SYNC_STAGES(2), .DOWN_CYCLES(DOWN), .UP_CYCLES(UP),
    .SAMPLE_DIV(DIV), .WAIT_HPF_OFF(WOFF), .WAIT_HPF_ON(WON)
  ) dut (
    .clk(clk), .rst_n(rst_n), .stby_n_in(stby_n), .hpf_on(hpf_in),
    .core_clk_en(core_clk_en), .ana_en(ana_en), .port_oe(port_oe),
    .ovl_force_lo(ovl_force_lo), .sd_hold_lo(sd_hold_lo)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_standby(input string tag);
    chk(tag, {core_clk_en, ana_en, port_oe, ovl_force_lo, sd_hold_lo}, 5'b00011);
  endtask

  // Drives stby_n to lvl0, optionally toggles it after toggle_at negedges,
  // and records the first edge of each output counted in clock cycles.
  task automatic run_seq(input logic lvl0, input int toggle_at, input logic hpf,
                         input logic flip, input int len);
    logic p_ana, p_oe, p_clk, p_hold;
    @(negedge clk);
    p_ana = ana_en; p_oe = port_oe; p_clk = core_clk_en; p_hold = sd_hold_lo;
    stby_n = lvl0;
    hpf_in = hpf;
    r_ana_on = -1; r_ana_off = -1; r_oe_on = -1; r_oe_off = -1; r_clk_off = -1; r_run = -1;
    for (int n = 1; n <= len; n++) begin
      @(negedge clk);
      if (ana_en && !p_ana && r_ana_on < 0)      r_ana_on = n;
      if (!ana_en && p_ana && r_ana_off < 0)     r_ana_off = n;
      if (port_oe && !p_oe && r_oe_on < 0)       r_oe_on = n;
      if (!port_oe && p_oe && r_oe_off < 0)      r_oe_off = n;
      if (!core_clk_en && p_clk && r_clk_off < 0) r_clk_off = n;
      if (!sd_hold_lo && p_hold && r_run < 0)    r_run = n;
      p_ana = ana_en; p_oe = port_oe; p_clk = core_clk_en; p_hold = sd_hold_lo;
      if (n == toggle_at) stby_n = ~stby_n;
      if (flip && n == 30) hpf_in = ~hpf_in;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual_cycles=200000 expected=fewer");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk_standby("R1 reset outputs");

    // R1/R2/R5/R6: release reset with standby deasserted
    @(negedge clk);
    rst_n = 1'b1;
    r_ana_on = -1; r_oe_on = -1; r_run = -1;
    for (int n = 1; n <= 80; n++) begin
      @(negedge clk);
      if (ana_en && r_ana_on < 0)      r_ana_on = n;
      if (port_oe && r_oe_on < 0)      r_oe_on = n;
      if (!sd_hold_lo && r_run < 0)    r_run = n;
    end
    chk("R2 wake latency after reset", r_ana_on, LAT);
    chk("R5 settle length after reset", r_oe_on, EXP_OE);
    chk("R6 data wait hpf off after reset", r_run, EXP_RUN_OFF);

    // Table of shutdown/wake cycles
    for (int v = 0; v < 4; v++) begin
      run_seq(1'b0, -1, 1'b0, 1'b0, 20);
      chk("R2 port off latency", r_oe_off, LAT);
      chk("R3 clock gate after shutdown", r_clk_off, LAT + DOWN);
      chk("R3 analog off after shutdown", r_ana_off, LAT + DOWN);
      chk_standby("R4 standby outputs");
      run_seq(1'b1, -1, VEC_HPF[v], VEC_FLIP[v], 130);
      chk("R2 analog on latency", r_ana_on, LAT);
      chk("R5 port enable after settle", r_oe_on, EXP_OE);
      if (VEC_FLIP[v]) chk("R7 hpf change during wait ignored", r_run, VEC_RUN[v]);
      else             chk("R6 data wait length", r_run, VEC_RUN[v]);
    end

    // R8: request during settling
    run_seq(1'b0, -1, 1'b0, 1'b0, 20);
    run_seq(1'b1, 8, 1'b0, 1'b0, 60);
    chk("R8 analog off after request in settle", r_ana_off, 8 + LAT + DOWN);
    chk("R8 port never enabled", r_oe_on, -1);
    chk_standby("R8 standby reached");

    // R8: request during data wait
    run_seq(1'b1, 30, 1'b0, 1'b0, 80);
    chk("R8 port on before request", r_oe_on, EXP_OE);
    chk("R8 analog off after request in wait", r_ana_off, 30 + LAT + DOWN);
    chk("R8 data never released", r_run, -1);

    // R10: request collides with end of data wait
    run_seq(1'b1, EXP_RUN_OFF - LAT, 1'b0, 1'b0, 80);
    chk("R10 data never released", r_run, -1);
    chk("R10 port off on collision edge", r_oe_off, EXP_RUN_OFF);
    chk("R10 clock off after shutdown", r_clk_off, EXP_RUN_OFF + DOWN);

    // Return to running
    run_seq(1'b1, -1, 1'b0, 1'b0, 70);
    chk("R6 running again", r_run, EXP_RUN_OFF);

    // R9: one-cycle pulse while running
    run_seq(1'b0, 1, 1'b0, 1'b0, 90);
    chk("R9 short pulse full shutdown", r_clk_off, LAT + DOWN);
    chk("R9 short pulse wake", r_ana_on, LAT + DOWN + 1);
    chk("R9 short pulse port on", r_oe_on, LAT + DOWN + 1 + UP);
    chk("R9 short pulse recovers", r_run, LAT + DOWN + 1 + UP + DIV * WOFF);

    // R9: release during shutdown does not shorten it
    run_seq(1'b0, 5, 1'b0, 1'b0, 90);
    chk("R9 release in shutdown ignored", r_clk_off, LAT + DOWN);
    chk("R9 wake after shutdown", r_ana_on, LAT + DOWN + 1);
    chk("R9 recovers after release in shutdown", r_run, LAT + DOWN + 1 + UP + DIV * WOFF);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule